// File: doc/BRIEF.md
# Reset-configured pin function multiplexer

An eight-lane pin multiplexer. Each pin works either as a general-purpose I/O or as a dedicated bus control line. One bit of a per-pin function register chooses between the two. In I/O mode a direction register and a data latch set what the pin does. In bus mode the pin passes through the output value and output enable that an external bus controller provides for that lane. One lane, index 3, has no bus-control counterpart, so it stays an I/O pin whatever its function bit holds.

Two strap inputs set the function register's contents at start-up. The block samples them on every clock edge while reset is low. If both straps are high at the last sampled edge, every pin comes up in bus mode. Otherwise every pin comes up as I/O. After reset, software can read and write the data, direction and function registers through a small register port. The address decodes as 0 = data, 1 = direction, 2 = function. A write lands on the next rising clock.

Top module: `pin_func_mux`

## Requirements
- R1: If both straps are high at the last clock edge of reset, the function register reads 0xFF at address 2 once reset is released.
- R2: If either strap is low at the last clock edge of reset, the function register reads 0x00 after release.
- R3: Only the strap values at the last reset edge count; earlier values during the same reset have no effect.
- R4: When a lane's function bit is 1 and the lane has a bus-control counterpart, `pin_oe` and `pin_out` of that lane equal `ctl_oe` and `ctl_out` of the same lane.
- R5: When a lane is in I/O mode, `pin_oe` equals its direction bit (1 = drive) and `pin_out` equals its data latch bit.
- R6: Lane 3 always behaves as in R5, even when its function bit is 1.
- R7: A read of address 0 returns `pin_in` for lanes that are in I/O mode with direction 0. For every other lane it returns the latch value.
- R8: A write with `wr_en` high stores `wr_data` into the register at `reg_addr` (0 data, 1 direction, 2 function) at the next rising edge. Reads of addresses 1 and 2 return the stored values. Address 3 reads 0x00, and a write to it changes no register.
- R9: After reset the data and direction registers are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; straps sampled while low |
| strap_a | input | 1 | First reset-time strap |
| strap_b | input | 1 | Second reset-time strap |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| ctl_oe | input | 8 | Per-lane output enable from the bus controller |
| ctl_out | input | 8 | Per-lane output value from the bus controller |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Value to drive on each pin |
| pin_oe | output | 8 | Per-pin driver enable |

## Verification
A function-register write can fall in the same cycle as the bus controller changing its lane values. Likewise, a data-register write can fall in the same cycle as a read of that register while `pin_in` changes. The bench provokes both by interleaving writes to every address with new `ctl_*` and `pin_in` patterns on every cycle. A behavioural model predicts the outcome, with the old mode and old latch holding until the edge and the new ones taking over after it. Every output is compared once per cycle. The checks are tagged by the lane class they concern: bus-mode lanes, I/O lanes and lane 3.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_DIR    = 2'd1,
    SEL_FUNC   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Start-up function-register fill: all bus mode only when both straps are high.
  function automatic logic straps_pick_bus(input logic a, input logic b);
    return a & b;
  endfunction

  // One lane of the output mux.
  function automatic logic lane_pick(input logic use_alt, input logic alt_v, input logic io_v);
    return use_alt ? alt_v : io_v;
  endfunction

endpackage

// File: rtl/pfm_regs.sv
module pfm_regs
  import pfm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_a,
  input  logic         strap_b,
  input  logic         wr_en,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] fun_q
);

  reg_sel_e sel;
  logic     wr_dat, wr_dir, wr_fun;
  logic     boot_bus;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_dat   = wr_en && (sel == SEL_DATA);
  assign wr_dir   = wr_en && (sel == SEL_DIR);
  assign wr_fun   = wr_en && (sel == SEL_FUNC);
  assign boot_bus = straps_pick_bus(strap_a, strap_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fun_q <= {W{boot_bus}};
      dat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_dat) dat_q <= wr_data;
      if (wr_dir) dir_q <= wr_data;
      if (wr_fun) fun_q <= wr_data;
    end
  end

  // R1 / R2 / R3: the fill on release follows the straps of the last reset edge
  assert_strap_fill_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (fun_q == {W{$past(strap_a) & $past(strap_b)}}));

  assert_reset_clear_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (dat_q == '0 && dir_q == '0));

  assert_fun_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fun |=> (fun_q == $past(wr_data)));

  assert_dat_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (dat_q == $past(wr_data)));

endmodule

// File: rtl/pfm_pin_slice.sv
module pfm_pin_slice
  import pfm_pkg::*;
#(
  parameter bit HAS_ALT = 1'b1
) (
  input  logic fun_bit,
  input  logic dir_bit,
  input  logic dat_bit,
  input  logic ctl_oe,
  input  logic ctl_out,
  input  logic pin_in,
  output logic bus_mode,
  output logic pin_oe,
  output logic pin_out,
  output logic rd_bit
);

  generate
    if (HAS_ALT) begin : g_alt
      assign bus_mode = fun_bit;
    end else begin : g_io_only
      logic unused_lane;
      assign unused_lane = fun_bit ^ ctl_oe ^ ctl_out;
      assign bus_mode    = 1'b0;
    end
  endgenerate

  assign pin_oe  = lane_pick(bus_mode, ctl_oe,  dir_bit);
  assign pin_out = lane_pick(bus_mode, ctl_out, dat_bit);
  assign rd_bit  = (!bus_mode && !dir_bit) ? pin_in : dat_bit;

endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
  import pfm_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] ALT_MASK = 8'hF7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap_a,
  input  logic         strap_b,
  input  logic         wr_en,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] ctl_oe,
  input  logic [W-1:0] ctl_out,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);

  logic [W-1:0] dat_q, dir_q, fun_q;
  logic [W-1:0] bus_mode;
  logic [W-1:0] dat_view;

  pfm_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_a  (strap_a),
    .strap_b  (strap_b),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .dat_q    (dat_q),
    .dir_q    (dir_q),
    .fun_q    (fun_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_lane
    pfm_pin_slice #(.HAS_ALT(ALT_MASK[i])) u_slice (
      .fun_bit  (fun_q[i]),
      .dir_bit  (dir_q[i]),
      .dat_bit  (dat_q[i]),
      .ctl_oe   (ctl_oe[i]),
      .ctl_out  (ctl_out[i]),
      .pin_in   (pin_in[i]),
      .bus_mode (bus_mode[i]),
      .pin_oe   (pin_oe[i]),
      .pin_out  (pin_out[i]),
      .rd_bit   (dat_view[i])
    );

    if (ALT_MASK[i]) begin : g_chk_alt
      assert_bus_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fun_q[i] |-> (pin_oe[i] == ctl_oe[i] && pin_out[i] == ctl_out[i]));
    end else begin : g_chk_io
      assert_no_alt_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[i] == dir_q[i] && pin_out[i] == dat_q[i]));
    end

    assert_input_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == SEL_DATA && !bus_mode[i] && !dir_q[i]) |-> (rd_data[i] == pin_in[i]));
  end

  always_comb begin
    case (reg_sel_e'(reg_addr))
      SEL_DATA: rd_data = dat_view;
      SEL_DIR:  rd_data = dir_q;
      SEL_FUNC: rd_data = fun_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: tb/pin_func_mux_test.sv
module pin_func_mux_test;

  logic       clk = 1'b0;
  logic       rst_n, strap_a, strap_b, wr_en;
  logic [1:0] reg_addr;
  logic [7:0] wr_data, rd_data, ctl_oe, ctl_out, pin_in, pin_out, pin_oe;

  int  vectors = 0;
  int  miscompares = 0;
  bit  armed = 0;
  bit  done = 0;

  logic [7:0] m_dat, m_dir, m_fun;

  always #10 clk = ~clk;

  pin_func_mux uut (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .ctl_oe(ctl_oe), .ctl_out(ctl_out), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural model of the register state
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fun <= (strap_a === 1'b1 && strap_b === 1'b1) ? 8'hFF : 8'h00;
      m_dat <= 8'h00;
      m_dir <= 8'h00;
    end else if (wr_en) begin
      if (reg_addr == 2'd0) m_dat <= wr_data;
      else if (reg_addr == 2'd1) m_dir <= wr_data;
      else if (reg_addr == 2'd2) m_fun <= wr_data;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (armed && rst_n) begin
      logic [7:0] e_oe, e_out, e_rd, m_bus, m_io;
      for (int i = 0; i < 8; i++) begin
        bit alt;
        alt = (i != 3) && m_fun[i];
        m_bus[i] = alt;
        m_io[i]  = !alt && (i != 3);
        e_oe[i]  = alt ? ctl_oe[i]  : m_dir[i];
        e_out[i] = alt ? ctl_out[i] : m_dat[i];
        e_rd[i]  = (!alt && !m_dir[i]) ? pin_in[i] : m_dat[i];
      end
      chk("R4 oe",  pin_oe  & m_bus, e_oe  & m_bus);
      chk("R4 out", pin_out & m_bus, e_out & m_bus);
      chk("R5 oe",  pin_oe  & m_io,  e_oe  & m_io);
      chk("R5 out", pin_out & m_io,  e_out & m_io);
      chk("R6 lane3", {6'b0, pin_oe[3], pin_out[3]}, {6'b0, m_dir[3], m_dat[3]});
      case (reg_addr)
        2'd0: chk("R7 read data", rd_data, e_rd);
        2'd1: chk("R8 read dir", rd_data, m_dir);
        2'd2: chk("R8 read func", rd_data, m_fun);
        default: chk("R8 read addr3", rd_data, 8'h00);
      endcase
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic do_reset(input logic a0, input logic b0, input logic a1, input logic b1);
    rst_n = 1'b0; wr_en = 1'b0;
    strap_a = a0; strap_b = b0;
    repeat (3) tick();
    strap_a = a1; strap_b = b1;
    tick();
    rst_n = 1'b1;
    armed = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; strap_a = 1'b1; strap_b = 1'b1; wr_en = 1'b0;
    reg_addr = 2'd0; wr_data = 8'h00; ctl_oe = 8'h00; ctl_out = 8'h00; pin_in = 8'h00;

    // R1 and R3: straps low earlier in reset, both high at the last edge
    do_reset(1'b1, 1'b0, 1'b1, 1'b1);
    reg_addr = 2'd2; #1;
    chk("R1 func after reset", rd_data, 8'hFF);
    reg_addr = 2'd1; #1;
    chk("R9 dir after reset", rd_data, 8'h00);
    reg_addr = 2'd0; #1;
    chk("R9 data after reset", rd_data, 8'h00);

    // bus-mode lanes follow the controller, lane 3 stays I/O
    for (int k = 0; k < 16; k++) begin
      ctl_oe = 8'(k * 37); ctl_out = 8'(~(k * 53)); pin_in = 8'(k * 11);
      tick();
    end

    wr(2'd1, 8'h0F);
    wr(2'd0, 8'hA5);
    wr(2'd0, 8'h08);
    #1;
    chk("R6 lane3 drives latch", {6'b0, pin_oe[3], pin_out[3]}, 8'h03);

    // write to address 3 changes nothing
    wr(2'd3, 8'h5A);
    reg_addr = 2'd1; #1; chk("R8 dir untouched by addr3", rd_data, 8'h0F);
    reg_addr = 2'd2; #1; chk("R8 func untouched by addr3", rd_data, 8'hFF);
    reg_addr = 2'd0; #1; chk("R8 data untouched by addr3", rd_data & 8'hF7, 8'h00);

    // mixed modes, writes interleaved with controller and pin changes
    wr(2'd2, 8'h3C);
    for (int k = 0; k < 48; k++) begin
      wr_en    = (k % 3 == 0);
      reg_addr = 2'(k % 4);
      wr_data  = 8'(k * 29 + 7);
      pin_in   = 8'(k * 71);
      ctl_oe   = 8'(k * 13);
      ctl_out  = 8'(k * 91);
      tick();
    end
    wr_en = 1'b0;

    // R7: all I/O inputs return pin level
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    pin_in = 8'h96; reg_addr = 2'd0; #1;
    chk("R7 all inputs show pins", rd_data, 8'h96);

    // R2 and R3: both high earlier, one low at the last edge
    do_reset(1'b1, 1'b1, 1'b0, 1'b1);
    reg_addr = 2'd2; #1;
    chk("R2 func after reset", rd_data, 8'h00);
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    reg_addr = 2'd2; #1;
    chk("R3 last edge wins", rd_data, 8'hFF);
    do_reset(1'b1, 1'b1, 1'b1, 1'b0);
    reg_addr = 2'd2; #1;
    chk("R3 last edge low wins", rd_data, 8'h00);

    for (int k = 0; k < 24; k++) begin
      wr_en    = (k % 2 == 0);
      reg_addr = 2'((k * 3) % 4);
      wr_data  = 8'(k * 83 + 1);
      pin_in   = 8'(k * 19);
      ctl_oe   = 8'(~(k * 7));
      ctl_out  = 8'(k * 45);
      tick();
    end
    wr_en = 1'b0;
    tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule